// File: doc/BRIEF.md
# Parallel Control-Register Write Port

This block is the host-facing load path for a numerically controlled oscillator. A processor puts a 16-bit word and a 3-bit slot number on the bus and pulses an active-low write strobe. On the strobe's rising edge the word and slot number are held in a small register that runs on the strobe itself, and a toggle flag in that domain changes state. The flag crosses into the master-clock domain through a flop chain. An edge on the synchronized flag gives a single-cycle commit pulse, and that pulse copies the held word into the destination register.

The destinations are two 32-bit frequency words, each loaded one 16-bit half at a time, and four 12-bit phase offsets. All of them drive the oscillator core continuously. The two halves of a frequency word are independent registers. A new frequency word therefore takes effect half by half, and the core sees a mixed word between the two writes.

Top module: `dds_parwr`

## Requirements
- R1: While `rst_n` is low, every frequency and phase output is zero, and the outputs stay zero after release until the first write commits.
- R2: The slot map decides the destination. Slot 0 is bits 15:0 of frequency 0 and slot 1 is its bits 31:16. Slot 2 is bits 15:0 of frequency 1 and slot 3 is its bits 31:16. Slots 4, 5, 6 and 7 are phase registers 0, 1, 2 and 3.
- R3: A phase write stores data bits 11:0. Data bits 15:12 have no effect on any output.
- R4: With the default two synchronizer stages, a write takes effect on the third master-clock rising edge after the strobe's rising edge. Outputs after the second edge still show the old value. This count holds whether the strobe rises just after a clock edge or just before one.
- R5: A write changes only the addressed 16-bit half or phase register. The other half of the same frequency word and every other register keep their values.
- R6: Holding the strobe low writes nothing, whatever the bus carries. Only the rising edge of the strobe starts a write.
- R7: Bus activity while the strobe is high has no effect on any output.
- R8: A series of writes lands in order and each one is kept, provided strobe rising edges are at least SYNC_STAGES+2 master-clock periods apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_n | input | 1 | Active-low write strobe; its rising edge captures the bus |
| data_i | input | 16 | Write data |
| addr_i | input | 3 | Destination slot number |
| freq_o | output | 64 | Frequency words; word k occupies bits 32k+31:32k |
| phase_o | output | 48 | Phase offsets; register k occupies bits 12k+11:12k |

## Verification
The write strobe rises at a random sub-cycle offset after a clock edge, from 0.3 ns to 4.7 ns, which includes both the just-after-edge case and the just-before-edge case. In every case the written register must change exactly at the third following clock edge. The bench counts clock edges from the strobe's rise. It compares all outputs with its model 1 ns after the second edge, where the old value must still be present, and 1 ns after the third edge, where the new value must be present. The bus is scrambled immediately after each rising edge and a long low strobe is held, and both are checked by the same full-state compare.

// File: rtl/dds_wr_pkg.sv
package dds_wr_pkg;

   localparam int unsigned DEF_DATA_W      = 16;
   localparam int unsigned DEF_ADDR_W      = 3;
   localparam int unsigned DEF_FREQ_W      = 32;
   localparam int unsigned DEF_PHASE_W     = 12;
   localparam int unsigned DEF_N_FREQ      = 2;
   localparam int unsigned DEF_N_PHASE     = 4;
   localparam int unsigned DEF_SYNC_STAGES = 2;

   // number of 16-bit slots that a configuration decodes
   function automatic int unsigned slot_count(int unsigned n_freq, int unsigned n_phase);
      return 2 * n_freq + n_phase;
   endfunction

endpackage

// File: rtl/dds_wr_capture.sv
// Strobe-domain holding register and toggle flag.
module dds_wr_capture #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 3
) (
   input  logic              wr_n,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] data_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [DATA_W-1:0] hold_data,
   output logic [ADDR_W-1:0] hold_addr,
   output logic              hold_tgl
);

   always_ff @(posedge wr_n or negedge rst_n) begin
      if (!rst_n) begin
         hold_data <= '0;
         hold_addr <= '0;
         hold_tgl  <= 1'b0;
      end else begin
         hold_data <= data_i;
         hold_addr <= addr_i;
         hold_tgl  <= ~hold_tgl;
      end
   end

endmodule

// File: rtl/dds_wr_sync.sv
// Flop chain for the toggle flag plus edge detect that yields the commit pulse.
module dds_wr_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tgl_async,
   output logic commit
);

   logic [STAGES-1:0] chain;
   logic              seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= 1'b0;
      else        chain[0] <= tgl_async;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= 1'b0;
         else        chain[s] <= chain[s-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen <= 1'b0;
      else        seen <= chain[STAGES-1];
   end

   assign commit = chain[STAGES-1] ^ seen;

endmodule

// File: rtl/dds_wr_decode.sv
// Slot number to one-hot write enables, gated by the commit pulse.
module dds_wr_decode #(
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned SLOTS  = 8
) (
   input  logic              commit,
   input  logic [ADDR_W-1:0] addr,
   output logic [SLOTS-1:0]  en
);

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      assign en[s] = commit && (addr == ADDR_W'(s));
   end

endmodule

// File: rtl/dds_wr_regs.sv
// Destination registers: frequency words as independent halves, then phase registers.
module dds_wr_regs #(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned FREQ_W  = 32,
   parameter int unsigned PHASE_W = 12,
   parameter int unsigned N_FREQ  = 2,
   parameter int unsigned N_PHASE = 4,
   localparam int unsigned SLOTS  = 2 * N_FREQ + N_PHASE
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [SLOTS-1:0]           en,
   input  logic [DATA_W-1:0]          wdata,
   output logic [N_FREQ*FREQ_W-1:0]   freq_o,
   output logic [N_PHASE*PHASE_W-1:0] phase_o
);

   localparam int unsigned HALF_W = FREQ_W / 2;

   for (genvar f = 0; f < N_FREQ; f++) begin : g_freq
      for (genvar h = 0; h < 2; h++) begin : g_half
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               freq_o[f*FREQ_W + h*HALF_W +: HALF_W] <= '0;
            else if (en[2*f + h])
               freq_o[f*FREQ_W + h*HALF_W +: HALF_W] <= wdata[HALF_W-1:0];
         end
      end
   end

   for (genvar p = 0; p < N_PHASE; p++) begin : g_phase
      logic [PHASE_W-1:0] nxt;
      if (PHASE_W == DATA_W) begin : g_full
         assign nxt = wdata;
      end else begin : g_trim
         assign nxt = wdata[PHASE_W-1:0];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            phase_o[p*PHASE_W +: PHASE_W] <= '0;
         else if (en[2*N_FREQ + p])
            phase_o[p*PHASE_W +: PHASE_W] <= nxt;
      end
   end

endmodule

// File: rtl/dds_parwr.sv
module dds_parwr
   import dds_wr_pkg::*;
#(
   parameter int unsigned DATA_W      = DEF_DATA_W,
   parameter int unsigned ADDR_W      = DEF_ADDR_W,
   parameter int unsigned FREQ_W      = DEF_FREQ_W,
   parameter int unsigned PHASE_W     = DEF_PHASE_W,
   parameter int unsigned N_FREQ      = DEF_N_FREQ,
   parameter int unsigned N_PHASE     = DEF_N_PHASE,
   parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_n,
   input  logic [DATA_W-1:0]          data_i,
   input  logic [ADDR_W-1:0]          addr_i,
   output logic [N_FREQ*FREQ_W-1:0]   freq_o,
   output logic [N_PHASE*PHASE_W-1:0] phase_o
);

   localparam int unsigned SLOTS = slot_count(N_FREQ, N_PHASE);

   if (FREQ_W != 2 * DATA_W) begin : g_bad_freq
      $error("frequency width must be two data words");
   end
   if (PHASE_W > DATA_W) begin : g_bad_phase
      $error("phase width exceeds data width");
   end
   if (SLOTS > (1 << ADDR_W)) begin : g_bad_addr
      $error("address too narrow for slot count");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("synchronizer needs at least two stages");
   end

   logic [DATA_W-1:0] hold_data;
   logic [ADDR_W-1:0] hold_addr;
   logic              hold_tgl;
   logic              commit;
   logic [SLOTS-1:0]  wr_en;

   dds_wr_capture #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cap (
      .wr_n      (wr_n),
      .rst_n     (rst_n),
      .data_i    (data_i),
      .addr_i    (addr_i),
      .hold_data (hold_data),
      .hold_addr (hold_addr),
      .hold_tgl  (hold_tgl)
   );

   dds_wr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .tgl_async (hold_tgl),
      .commit    (commit)
   );

   dds_wr_decode #(.ADDR_W(ADDR_W), .SLOTS(SLOTS)) u_dec (
      .commit (commit),
      .addr   (hold_addr),
      .en     (wr_en)
   );

   dds_wr_regs #(
      .DATA_W(DATA_W), .FREQ_W(FREQ_W), .PHASE_W(PHASE_W),
      .N_FREQ(N_FREQ), .N_PHASE(N_PHASE)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (wr_en),
      .wdata   (hold_data),
      .freq_o  (freq_o),
      .phase_o (phase_o)
   );

endmodule

// File: rtl/dds_parwr_chk.sv
module dds_parwr_chk #(
   parameter int unsigned FREQ_W  = 32,
   parameter int unsigned PHASE_W = 12,
   parameter int unsigned N_FREQ  = 2,
   parameter int unsigned N_PHASE = 4
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       commit,
   input logic [N_FREQ*FREQ_W-1:0]   freq_o,
   input logic [N_PHASE*PHASE_W-1:0] phase_o
);

   localparam int unsigned HALF_W = FREQ_W / 2;
   localparam int unsigned NREG   = 2 * N_FREQ + N_PHASE;

   logic [N_FREQ*FREQ_W-1:0]   prev_f;
   logic [N_PHASE*PHASE_W-1:0] prev_p;
   logic [NREG-1:0]            chg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_f <= '0;
         prev_p <= '0;
      end else begin
         prev_f <= freq_o;
         prev_p <= phase_o;
      end
   end

   for (genvar h = 0; h < 2 * N_FREQ; h++) begin : g_fc
      assign chg[h] = freq_o[h*HALF_W +: HALF_W] != prev_f[h*HALF_W +: HALF_W];
   end
   for (genvar p = 0; p < N_PHASE; p++) begin : g_pc
      assign chg[2*N_FREQ + p] = phase_o[p*PHASE_W +: PHASE_W] != prev_p[p*PHASE_W +: PHASE_W];
   end

   // R1: outputs are zero on the first edge after reset release
   a_r1_zero_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (freq_o == '0 && phase_o == '0));

   // R5: one commit touches at most one destination
   a_r5_single_dest: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(chg) <= 1);

   // R7: no register moves without a commit in the cycle before
   a_r7_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
      (chg != '0) |-> $past(commit));

   // R4: each write gives a single-cycle commit pulse
   a_r4_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> !commit);

endmodule

bind dds_parwr dds_parwr_chk #(
   .FREQ_W(FREQ_W), .PHASE_W(PHASE_W), .N_FREQ(N_FREQ), .N_PHASE(N_PHASE)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .commit  (commit),
   .freq_o  (freq_o),
   .phase_o (phase_o)
);

// File: tb/dds_parwr_test.sv
`timescale 1ns/1ps
module dds_parwr_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_n = 1'b1;
   logic [15:0] data_i = '0;
   logic [2:0]  addr_i = '0;
   logic [63:0] freq_o;
   logic [47:0] phase_o;

   int unsigned nvec = 0;
   int unsigned nbad = 0;
   bit          done = 1'b0;

   logic [31:0] exp_f [2];
   logic [11:0] exp_p [4];

   always #2.5 clk = ~clk;

   dds_parwr uut (
      .clk(clk), .rst_n(rst_n), .wr_n(wr_n),
      .data_i(data_i), .addr_i(addr_i),
      .freq_o(freq_o), .phase_o(phase_o)
   );

   function automatic logic [63:0] model_f();
      return {exp_f[1], exp_f[0]};
   endfunction

   function automatic logic [47:0] model_p();
      return {exp_p[3], exp_p[2], exp_p[1], exp_p[0]};
   endfunction

   // R2/R3: slot map applied to the model
   function automatic void apply(logic [2:0] a, logic [15:0] d);
      case (a)
         3'd0: exp_f[0][15:0]  = d;
         3'd1: exp_f[0][31:16] = d;
         3'd2: exp_f[1][15:0]  = d;
         3'd3: exp_f[1][31:16] = d;
         default: exp_p[a-3'd4] = d[11:0];
      endcase
   endfunction

   task automatic check_all(string req);
      nvec++;
      if (freq_o !== model_f() || phase_o !== model_p()) begin
         nbad++;
         $display("FAIL %s: freq %h phase %h, expected freq %h phase %h",
                  req, freq_o, phase_o, model_f(), model_p());
      end
   endtask

   // Strobe low mid-cycle, rise 'rise' ns after the next edge, then scramble the bus.
   task automatic do_write(logic [2:0] a, logic [15:0] d, real rise, string req);
      @(posedge clk);
      #2.5;
      addr_i = a; data_i = d; wr_n = 1'b0;
      @(posedge clk);
      #(rise);
      wr_n = 1'b1;
      #0.2;
      addr_i = 3'($urandom); data_i = 16'($urandom);   // R7: bus noise while strobe high
      @(posedge clk);
      @(posedge clk);
      #1;
      check_all({req, " R4 old value after second edge"});
      @(posedge clk);
      #1;
      apply(a, d);
      check_all(req);
   endtask

   initial begin
      void'($urandom(32'h5eed_1234));
      for (int i = 0; i < 2; i++) exp_f[i] = '0;
      for (int i = 0; i < 4; i++) exp_p[i] = '0;
      data_i = 16'hFFFF; addr_i = 3'd7;
      repeat (3) @(posedge clk);
      #1;
      check_all("R1 during reset");
      rst_n = 1'b1;
      repeat (4) @(posedge clk);
      #1;
      check_all("R1 after release");

      // R2/R5: every slot, distinct patterns; halves stay independent
      do_write(3'd0, 16'h1111, 2.0, "R2 slot0");
      do_write(3'd1, 16'h2222, 2.0, "R2 slot1");
      do_write(3'd2, 16'h3333, 2.0, "R2 slot2");
      do_write(3'd3, 16'h4444, 2.0, "R2 slot3");
      do_write(3'd4, 16'h0555, 2.0, "R2 slot4");
      do_write(3'd5, 16'h0666, 2.0, "R2 slot5");
      do_write(3'd6, 16'h0777, 2.0, "R2 slot6");
      do_write(3'd7, 16'h0888, 2.0, "R2 slot7");
      do_write(3'd1, 16'hABCD, 3.0, "R5 high half only");
      // R3: upper data bits ignored on phase writes
      do_write(3'd5, 16'hF123, 2.0, "R3 phase upper bits");
      // R4: strobe just after and just before an edge
      do_write(3'd2, 16'hBEEF, 0.3, "R4 rise just after edge");
      do_write(3'd6, 16'h0ACE, 4.7, "R4 rise just before edge");

      // R6: strobe held low with valid bus writes nothing
      @(posedge clk);
      #2.5;
      addr_i = 3'd0; data_i = 16'hDEAD; wr_n = 1'b0;
      repeat (8) @(posedge clk);
      #1;
      check_all("R6 strobe held low");
      wr_n = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      apply(3'd0, 16'hDEAD);
      check_all("R6 completes on rising edge");

      // R8: random back-to-back writes at random rise offsets
      for (int n = 0; n < 60; n++) begin
         real off;
         off = 0.3 + real'($urandom % 45) / 10.0;
         do_write(3'($urandom), 16'($urandom), off, "R8 random sequence");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         nvec++;
         nbad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end

endmodule